// File: doc/BRIEF.md
# TDO Capture Packer

This block sits beside a boundary-scan sequencer and keeps the serial data that comes back from the scan chain. Each time the sequencer marks a sampled TDO bit as valid while the TAP is shifting the instruction register or a data register, the bit is appended to a right-justified 32-bit accumulator. When the accumulator is full, it becomes one write to a small result memory, which software reads later and compares against expected data with a mask.

Two suppress controls choose, independently, whether instruction-shift bits and data-shift bits are kept. Together they give four recording modes: both, data only, instruction only, and nothing. A flush request at the end of a test writes out a partly filled word, so the memory matches the bit count. A clear pulse restarts the capture. Status gets a saturating count of recorded bits and the address of the most recent write.

Top module: `tdo_capture_packer`

## Requirements
- R1: While rst_ni is low, mem_we_o, mem_addr_o, mem_wdata_o, last_addr_o and bit_count_o are all zero.
- R2: A bit is recorded only on a clock edge where bit_valid_i is high and shift_ir_i or shift_dr_i is high. Any other edge leaves bit_count_o unchanged.
- R3: skip_ir_i high drops bits taken during instruction shift (shift_ir_i), and skip_dr_i high drops bits taken during data shift (shift_dr_i). Each control has no effect on the other shift kind.
- R4: Recorded bits enter at bit 0 of the accumulator and move earlier bits toward bit 31. So a word sent most significant bit first is written back unchanged. The clock edge that records the 32nd bit raises mem_we_o for exactly the following cycle, and mem_wdata_o carries the packed word.
- R5: Memory writes use addresses 0, 1, 2 and so on in order. Each write updates last_addr_o to its own address at the same edge that raises mem_we_o.
- R6: bit_count_o goes up by one at every edge that records a bit.
- R7: flush_i with a partly filled accumulator writes that word right-justified, with zeros above. A bit recorded in the same cycle as the flush is included. flush_i with an empty accumulator writes nothing.
- R8: After DEPTH words have been written, no further write is issued and last_addr_o holds its value.
- R9: bit_count_o saturates at 2^CNT_W-1.
- R10: clear_i sets bit_count_o, the write address, last_addr_o and the accumulator to zero. It overrides a bit offered in the same cycle, and no write follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock (sampling edge of TCK) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous restart of capture state |
| bit_valid_i | input | 1 | TDO sample valid this cycle |
| tdo_i | input | 1 | Sampled test data output |
| shift_ir_i | input | 1 | TAP in instruction shift state |
| shift_dr_i | input | 1 | TAP in data shift state |
| skip_ir_i | input | 1 | Suppress recording during instruction shift |
| skip_dr_i | input | 1 | Suppress recording during data shift |
| flush_i | input | 1 | Write out a partial word |
| mem_we_o | output | 1 | Result memory write enable |
| mem_addr_o | output | ADDR_W | Result memory write address |
| mem_wdata_o | output | WORD_W | Result memory write data |
| last_addr_o | output | ADDR_W | Address of the most recent write |
| bit_count_o | output | CNT_W | Saturating count of recorded bits |

## Verification
The bench keeps WORD_W at 32, so the packing order and the full-word write are tested at the real width. It reduces DEPTH to 4 and CNT_W to 8. With these values the memory fills after 128 recorded bits and the counter saturates at 255, so the full-memory drop and the saturation are both reached in a few hundred cycles. The gating rules of the four recording modes are walked from a vector table. Flush with and without a pending bit, and clear against a concurrent bit, are directed cases.

// File: rtl/tcp_pkg.sv
package tcp_pkg;

  typedef struct packed {
    logic in_ir;
    logic in_dr;
    logic skip_ir;
    logic skip_dr;
  } rec_ctl_t;

  function automatic logic rec_enable(rec_ctl_t c);
    return (c.in_ir & ~c.skip_ir) | (c.in_dr & ~c.skip_dr);
  endfunction

endpackage

// File: rtl/tcp_qualify.sv
module tcp_qualify
  import tcp_pkg::*;
(
  input  logic     bit_valid_i,
  input  rec_ctl_t ctl_i,
  output logic     accept_o
);
  assign accept_o = bit_valid_i & rec_enable(ctl_i);
endmodule

// File: rtl/tcp_shifter.sv
module tcp_shifter #(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              accept_i,
  input  logic              tdo_i,
  input  logic              flush_i,
  output logic              emit_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int FILL_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh_q, sh_nxt;
  logic [FILL_W-1:0] fill_q, fill_nxt;
  logic              word_full;

  always_comb begin
    sh_nxt   = accept_i ? {sh_q[WORD_W-2:0], tdo_i} : sh_q;
    fill_nxt = fill_q + FILL_W'(accept_i);
  end

  assign word_full = (fill_nxt == FILL_W'(WORD_W));
  assign emit_o    = ~clear_i & (word_full | (flush_i & (fill_nxt != '0)));
  assign word_o    = sh_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      fill_q <= '0;
    end else if (clear_i || emit_o) begin
      sh_q   <= '0;
      fill_q <= '0;
    end else begin
      sh_q   <= sh_nxt;
      fill_q <= fill_nxt;
    end
  end
endmodule

// File: rtl/tcp_writer.sv
module tcp_writer #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 64
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     emit_i,
  input  logic [WORD_W-1:0]        word_i,
  output logic                     mem_we_o,
  output logic [$clog2(DEPTH)-1:0] mem_addr_o,
  output logic [WORD_W-1:0]        mem_wdata_o,
  output logic [$clog2(DEPTH)-1:0] last_addr_o
);
  localparam int ADDR_W  = $clog2(DEPTH);
  localparam int WORDS_W = ADDR_W + 1;

  logic [WORDS_W-1:0] words_q;
  logic               mem_full;
  logic               do_wr;

  // DEPTH is a power of two, so the low bits of the word count are the pointer
  assign mem_full = (words_q == WORDS_W'(DEPTH));
  assign do_wr    = emit_i & ~mem_full & ~clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      words_q     <= '0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      last_addr_o <= '0;
    end else if (clear_i) begin
      words_q     <= '0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      last_addr_o <= '0;
    end else begin
      mem_we_o <= do_wr;
      if (do_wr) begin
        mem_addr_o  <= words_q[ADDR_W-1:0];
        mem_wdata_o <= word_i;
        last_addr_o <= words_q[ADDR_W-1:0];
        words_q     <= words_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tcp_counter.sv
module tcp_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         count_o <= '0;
    else if (clear_i)                    count_o <= '0;
    else if (inc_i && count_o != CNT_MAX) count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/tdo_capture_packer.sv
module tdo_capture_packer
  import tcp_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 12,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              bit_valid_i,
  input  logic              tdo_i,
  input  logic              shift_ir_i,
  input  logic              shift_dr_i,
  input  logic              skip_ir_i,
  input  logic              skip_dr_i,
  input  logic              flush_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic [ADDR_W-1:0] last_addr_o,
  output logic [CNT_W-1:0]  bit_count_o
);
  rec_ctl_t          ctl;
  logic              accept;
  logic              emit;
  logic [WORD_W-1:0] word;

  assign ctl = '{in_ir: shift_ir_i, in_dr: shift_dr_i,
                 skip_ir: skip_ir_i, skip_dr: skip_dr_i};

  tcp_qualify u_qual (
    .bit_valid_i(bit_valid_i),
    .ctl_i      (ctl),
    .accept_o   (accept)
  );

  tcp_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .accept_i(accept),
    .tdo_i   (tdo_i),
    .flush_i (flush_i),
    .emit_o  (emit),
    .word_o  (word)
  );

  tcp_writer #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear_i),
    .emit_i     (emit),
    .word_i     (word),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .last_addr_o(last_addr_o)
  );

  tcp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .inc_i  (accept),
    .count_o(bit_count_o)
  );
endmodule

// File: rtl/tcp_checker.sv
module tcp_checker #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 12,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              bit_valid_i,
  input logic              shift_ir_i,
  input logic              shift_dr_i,
  input logic              skip_ir_i,
  input logic              skip_dr_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [ADDR_W-1:0] last_addr_o,
  input logic [CNT_W-1:0]  bit_count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic        acc;
  logic [31:0] wr_seen;

  assign acc = bit_valid_i & ((shift_ir_i & ~skip_ir_i) | (shift_dr_i & ~skip_dr_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       wr_seen <= '0;
    else if (clear_i)  wr_seen <= '0;
    else if (mem_we_o) wr_seen <= wr_seen + 1;
  end

  a_r6_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !clear_i && bit_count_o != CNT_MAX) |=> bit_count_o == CNT_W'($past(bit_count_o) + 1'b1));

  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc && !clear_i) |=> $stable(bit_count_o));

  a_r9_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_count_o == CNT_MAX && !clear_i) |=> bit_count_o == CNT_MAX);

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (bit_count_o == '0 && last_addr_o == '0 && !mem_we_o));

  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> wr_seen < DEPTH);

  a_r5_addr_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o == wr_seen[ADDR_W-1:0] && last_addr_o == mem_addr_o));
endmodule

bind tdo_capture_packer tcp_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clear_i    (clear_i),
  .bit_valid_i(bit_valid_i),
  .shift_ir_i (shift_ir_i),
  .shift_dr_i (shift_dr_i),
  .skip_ir_i  (skip_ir_i),
  .skip_dr_i  (skip_dr_i),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .last_addr_o(last_addr_o),
  .bit_count_o(bit_count_o)
);

// File: tb/tb_tdo_capture_packer.sv
module tb_tdo_capture_packer;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 32;
  localparam int DEPTH  = 4;
  localparam int CNT_W  = 8;
  localparam int ADDR_W = $clog2(DEPTH);

  // {valid, in_ir, in_dr, skip_ir, skip_dr, expect_recorded}
  localparam int NVEC = 11;
  localparam logic [5:0] VEC [NVEC] = '{
    6'b11000_1, 6'b10100_1, 6'b10000_0, 6'b01000_0,
    6'b11010_0, 6'b10110_1, 6'b11001_1, 6'b10101_0,
    6'b11011_0, 6'b10111_0, 6'b00100_0
  };

  logic clk = 0, rst_n = 0;
  logic clear = 0, bit_valid = 0, tdo = 0, shift_ir = 0, shift_dr = 0;
  logic skip_ir = 0, skip_dr = 0, flush = 0;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr, last_addr;
  logic [WORD_W-1:0] mem_wdata;
  logic [CNT_W-1:0]  bit_count;

  int checks = 0, failures = 0;
  int n_wr = 0;
  logic [WORD_W-1:0] wr_data [16];
  logic [ADDR_W-1:0] wr_addr [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  tdo_capture_packer #(.WORD_W(WORD_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .bit_valid_i(bit_valid),
    .tdo_i(tdo), .shift_ir_i(shift_ir), .shift_dr_i(shift_dr),
    .skip_ir_i(skip_ir), .skip_dr_i(skip_dr), .flush_i(flush),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .last_addr_o(last_addr), .bit_count_o(bit_count)
  );

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (n_wr < 16) begin
        wr_data[n_wr] = mem_wdata;
        wr_addr[n_wr] = mem_addr;
      end
      n_wr = n_wr + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic t, input logic ir, input logic dr, input logic v, input logic fl);
    tdo = t; shift_ir = ir; shift_dr = dr; bit_valid = v; flush = fl;
    @(posedge clk); #1;
    bit_valid = 0; flush = 0; shift_ir = 0; shift_dr = 0;
  endtask

  task automatic send_word(input logic [WORD_W-1:0] w);
    for (int i = WORD_W-1; i >= 0; i--) send(w[i], 0, 1, 1, 0);
  endtask

  task automatic idle();
    send(0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [CNT_W-1:0] prev;
    int base;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(mem_we == 0 && mem_addr == 0 && mem_wdata == 0, "R1 port", {31'd0, mem_we}, 0);
    chk(last_addr == 0 && bit_count == 0, "R1 status", {24'd0, bit_count}, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;

    // R2 R3 gating table
    for (int i = 0; i < NVEC; i++) begin
      prev = bit_count;
      skip_ir = VEC[i][2]; skip_dr = VEC[i][1];
      send(1, VEC[i][4], VEC[i][3], VEC[i][5], 0);
      chk(bit_count == prev + CNT_W'(VEC[i][0]), $sformatf("R2/R3 vec%0d", i),
          {24'd0, bit_count}, {24'd0, prev + CNT_W'(VEC[i][0])});
    end
    skip_ir = 0; skip_dr = 0;
    chk(bit_count == 4, "R6 total", {24'd0, bit_count}, 4);

    // R7 flush of four ones
    send(0, 0, 0, 0, 1);
    idle();
    chk(n_wr == 1, "R7 flush count", n_wr, 1);
    chk(wr_data[0] == 32'h0000_000F, "R7 flush data", wr_data[0], 32'hF);
    chk(wr_addr[0] == 0 && last_addr == 0, "R5 first addr", {30'd0, last_addr}, 0);

    // R10 clear beats a concurrent bit
    clear = 1;
    send(1, 0, 1, 1, 0);
    clear = 0;
    idle();
    chk(bit_count == 0 && last_addr == 0, "R10 cleared", {24'd0, bit_count}, 0);
    chk(n_wr == 1, "R10 no write", n_wr, 1);

    // R4 packing order and single write pulse
    send_word(32'hA5C3_1E69);
    idle();
    chk(n_wr == 2, "R4 one write", n_wr, 2);
    chk(wr_data[1] == 32'hA5C3_1E69, "R4 word", wr_data[1], 32'hA5C3_1E69);
    chk(wr_addr[1] == 0, "R10 addr restart", {30'd0, wr_addr[1]}, 0);
    chk(bit_count == 32, "R6 after word", {24'd0, bit_count}, 32);

    send_word(32'h0000_0001);
    idle();
    chk(n_wr == 3 && wr_addr[2] == 1 && last_addr == 1, "R5 second addr", {30'd0, last_addr}, 1);

    // R7 partial flush including same-cycle bit
    send(1, 0, 1, 1, 0);
    send(0, 1, 0, 1, 0);
    send(1, 0, 1, 1, 0);
    send(1, 0, 1, 1, 1);
    idle();
    chk(n_wr == 4 && wr_data[3] == 32'h0000_000B, "R7 partial", wr_data[3], 32'hB);
    chk(last_addr == 2, "R5 third addr", {30'd0, last_addr}, 2);
    chk(bit_count == 68, "R6 count", {24'd0, bit_count}, 68);

    // R7 empty flush
    send(0, 0, 0, 0, 1);
    idle();
    chk(n_wr == 4, "R7 empty flush", n_wr, 4);

    // R8 fill memory then overflow
    send_word(32'hFFFF_FFFF);
    idle();
    chk(n_wr == 5 && wr_addr[4] == 3, "R5 last slot", {30'd0, wr_addr[4]}, 3);
    base = n_wr;
    send_word(32'h1234_5678);
    send(1, 0, 1, 1, 1);
    idle();
    chk(n_wr == base, "R8 dropped", n_wr, base);
    chk(last_addr == 3, "R8 last hold", {30'd0, last_addr}, 3);

    // R9 saturation
    for (int i = 0; i < 130; i++) send(1, 1, 0, 1, 0);
    chk(bit_count == 8'hFF, "R9 saturate", {24'd0, bit_count}, 32'hFF);
    send(1, 0, 1, 1, 0);
    chk(bit_count == 8'hFF, "R9 hold", {24'd0, bit_count}, 32'hFF);

    clear = 1; idle(); clear = 0;
    chk(bit_count == 0 && last_addr == 0, "R10 final clear", {24'd0, bit_count}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule